// File: doc/BRIEF.md
# Lock-Step Shared Register File with Write Merging

This block is a small register file shared by several processor ports that all take one access step together on each clock. In every step each port may read one word or write one word. All reads see the contents as they were before the step began. All writes that do not break the access rules are applied together at the end of the step. The read data comes out of a register one cycle later.

Two run-time inputs control the behaviour. The discipline input says whether reads of one address by several ports are allowed in a step, and whether writes to one address by several ports are allowed. When several ports may write one address, the resolution input picks how their data is combined into the single stored word.

Any step that breaks a rule raises a one-cycle conflict flag and leaves the affected word unchanged. A sticky error bit then records the event together with the address involved, and holds them until software clears them. Broadcasting one key to every port is a single legal read step. A parallel search can then finish in a fixed number of steps: every port writes a 0 or 1 match result to one flag word, and the writes are merged by OR.

Top module: `shmem_resolve`

## Requirements
- R1: After synchronous reset every word reads 0, `rd_vld` is 0, `step_err` is 0, `err_sticky` is 0 and `err_addr` is 0.
- R2: A port with `port_vld`=1 and `port_we`=0 reads its address. One cycle later its `rd_vld` bit is 1 and its `rd_data` slice holds the word as stored before that step's writes. Ports that do not read keep their previous `rd_data` and have `rd_vld` 0.
- R3: A port with `port_vld`=1 and `port_we`=1 that is the only writer of its address stores its `port_wdata` there at the end of the step.
- R4: With discipline 0 (concurrent writes legal) and resolution 0, colliding writers store the data of the lowest-numbered writing port.
- R5: With discipline 0 and resolution 1, colliding writers store the bitwise OR of all their data. All ports writing a 0/1 match bit to one flag word therefore store 1 exactly when any port wrote 1.
- R6: With discipline 0 and resolution 2, colliding writers store the largest of their data, compared as unsigned numbers.
- R7: With discipline 0 and resolution 3, a write collision is a violation.
- R8: With discipline 1 or 2/3 (exclusive writes), two or more writers to one address in a step is a violation, whatever the resolution. Single writers to distinct addresses in the same step are stored normally.
- R9: With discipline 2 or 3 (exclusive reads), two or more readers of one address in a step is a violation, and those readers still receive their data. With disciplines 0 and 1, any number of ports may read one address without a flag.
- R10: A violation leaves the word it concerns unchanged. `step_err` is 1 for exactly the cycle after a violating step.
- R11: `err_sticky` sets on a violation and stays set until `err_clr`. It captures into `err_addr` the address of the lowest-numbered port involved in the violation. That value is held while sticky; a violation in the same step as `err_clr` wins and captures its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disc | input | 2 | Access discipline: 0 concurrent read/write, 1 concurrent read exclusive write, 2/3 exclusive read/write |
| res | input | 2 | Write resolution: 0 lowest port, 1 OR, 2 maximum, 3 error |
| port_vld | input | NPORT | Per-port access request |
| port_we | input | NPORT | Per-port write select (0 read, 1 write) |
| port_addr | input | NPORT*AW | Per-port address, port i in bits [i*AW +: AW] |
| port_wdata | input | NPORT*DW | Per-port write data, port i in bits [i*DW +: DW] |
| err_clr | input | 1 | Clears the sticky error |
| rd_vld | output | NPORT | Per-port read data valid, registered |
| rd_data | output | NPORT*DW | Per-port read data, registered |
| step_err | output | 1 | Conflict in the previous step |
| err_sticky | output | 1 | Sticky error flag |
| err_addr | output | AW | Address captured with the sticky error |

## Verification
Directed steps cover the corner cases one at a time. Three ports write the same address under each resolution, with values chosen so that lowest-port, OR and maximum each store a different word. A read and a write of one address in the same step shows that reads see the old contents. A broadcast read and an OR-merged match flag reproduce the constant-step search. Paired readers and paired writers under each discipline show which collisions are flagged, and that a flagged word stays unchanged. The random phase confines addresses to a few words so that collisions are frequent. It mixes every discipline, resolution and clear, and a bench reference model tells apart errors in merge selection, violation detection and error capture.

// File: rtl/shm_pkg.sv
package shm_pkg;

    typedef enum logic [1:0] {
        DISC_CRCW  = 2'd0,
        DISC_CREW  = 2'd1,
        DISC_EREW  = 2'd2,
        DISC_EREW2 = 2'd3
    } disc_e;

    typedef enum logic [1:0] {
        RES_LOW = 2'd0,
        RES_OR  = 2'd1,
        RES_MAX = 2'd2,
        RES_ERR = 2'd3
    } res_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } op_t;

    function automatic logic excl_write(input disc_e d);
        return d != DISC_CRCW;
    endfunction

    function automatic logic excl_read(input disc_e d);
        return d[1];
    endfunction

    function automatic op_t decode_op(input logic vld, input logic we);
        op_t o;
        o.rd = vld & ~we;
        o.wr = vld & we;
        return o;
    endfunction

endpackage

// File: rtl/shm_match.sv
module shm_match #(
    parameter int NPORT = 4,
    parameter int AW    = 4
) (
    input  logic [NPORT-1:0]       rd,
    input  logic [NPORT-1:0]       wr,
    input  logic [NPORT*AW-1:0]    addr,
    output logic [NPORT*NPORT-1:0] wpeer,
    output logic [NPORT-1:0]       wcoll,
    output logic [NPORT-1:0]       rcoll
);
    localparam int CW = $clog2(NPORT + 1);

    logic [NPORT*NPORT-1:0] same;

    for (genvar i = 0; i < NPORT; i++) begin : g_row
        for (genvar j = 0; j < NPORT; j++) begin : g_col
            assign same[i*NPORT+j]  = addr[i*AW +: AW] == addr[j*AW +: AW];
            assign wpeer[i*NPORT+j] = wr[i] & wr[j] & same[i*NPORT+j];
        end

        always_comb begin
            logic [CW-1:0] nw;
            logic          orr;
            nw  = '0;
            orr = 1'b0;
            for (int j = 0; j < NPORT; j++) begin
                nw = nw + CW'(wpeer[i*NPORT+j]);
                if (j != i && rd[j] && same[i*NPORT+j]) orr = 1'b1;
            end
            wcoll[i] = wr[i] && (nw > CW'(1));
            rcoll[i] = rd[i] && orr;
        end
    end

endmodule

// File: rtl/shm_merge.sv
module shm_merge
    import shm_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int DW    = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  res_e                   res,
    input  logic [NPORT*NPORT-1:0] wpeer,
    input  logic [NPORT*DW-1:0]    wdata,
    output logic [NPORT*DW-1:0]    merged
);
    for (genvar i = 0; i < NPORT; i++) begin : g_port
        logic [DW-1:0] low_v, or_v, max_v;

        always_comb begin
            low_v = '0;
            or_v  = '0;
            max_v = '0;
            for (int j = NPORT - 1; j >= 0; j--) begin
                if (wpeer[i*NPORT+j]) begin
                    low_v = wdata[j*DW +: DW];
                    or_v  = or_v | wdata[j*DW +: DW];
                    if (wdata[j*DW +: DW] > max_v) max_v = wdata[j*DW +: DW];
                end
            end
        end

        always_comb begin
            unique case (res)
                RES_OR:  merged[i*DW +: DW] = or_v;
                RES_MAX: merged[i*DW +: DW] = max_v;
                default: merged[i*DW +: DW] = low_v;
            endcase
        end

        // R5
        or_cover_chk: assert property (@(posedge clk) disable iff (rst)
            (res == RES_OR && wpeer[i*NPORT+i]) |->
            ((merged[i*DW +: DW] & wdata[i*DW +: DW]) == wdata[i*DW +: DW]));

        // R6
        max_floor_chk: assert property (@(posedge clk) disable iff (rst)
            (res == RES_MAX && wpeer[i*NPORT+i]) |->
            (merged[i*DW +: DW] >= wdata[i*DW +: DW]));
    end

endmodule

// File: rtl/shm_store.sv
module shm_store #(
    parameter int NPORT = 4,
    parameter int AW    = 4,
    parameter int DW    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NPORT-1:0]    rd,
    input  logic [NPORT-1:0]    commit,
    input  logic [NPORT*AW-1:0] addr,
    input  logic [NPORT*DW-1:0] merged,
    output logic [NPORT-1:0]    rd_vld,
    output logic [NPORT*DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else begin
            for (int i = 0; i < NPORT; i++) begin
                if (commit[i]) mem[addr[i*AW +: AW]] <= merged[i*DW +: DW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_vld  <= '0;
            rd_data <= '0;
        end else begin
            rd_vld <= rd;
            for (int i = 0; i < NPORT; i++) begin
                if (rd[i]) rd_data[i*DW +: DW] <= mem[addr[i*AW +: AW]];
            end
        end
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_chk
        // R2
        rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !rd[i] |=> $stable(rd_data[i*DW +: DW]));
    end

endmodule

// File: rtl/shm_errlog.sv
module shm_errlog #(
    parameter int NPORT = 4,
    parameter int AW    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                err_clr,
    input  logic [NPORT-1:0]    viol,
    input  logic [NPORT*AW-1:0] addr,
    output logic                step_err,
    output logic                err_sticky,
    output logic [AW-1:0]       err_addr
);
    logic [AW-1:0] first_addr;

    always_comb begin
        first_addr = '0;
        for (int k = NPORT - 1; k >= 0; k--) begin
            if (viol[k]) first_addr = addr[k*AW +: AW];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_err   <= 1'b0;
            err_sticky <= 1'b0;
            err_addr   <= '0;
        end else begin
            step_err <= |viol;
            if (|viol) begin
                err_sticky <= 1'b1;
                if (!err_sticky || err_clr) err_addr <= first_addr;
            end else if (err_clr) begin
                err_sticky <= 1'b0;
            end
        end
    end

    // R11
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (err_sticky && !err_clr) |=> err_sticky);

    // R11
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (err_sticky && !err_clr) |=> $stable(err_addr));

    // R10
    step_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        step_err |-> err_sticky);

endmodule

// File: rtl/shmem_resolve.sv
module shmem_resolve
    import shm_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int AW    = 4,
    parameter int DW    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          disc,
    input  logic [1:0]          res,
    input  logic [NPORT-1:0]    port_vld,
    input  logic [NPORT-1:0]    port_we,
    input  logic [NPORT*AW-1:0] port_addr,
    input  logic [NPORT*DW-1:0] port_wdata,
    input  logic                err_clr,
    output logic [NPORT-1:0]    rd_vld,
    output logic [NPORT*DW-1:0] rd_data,
    output logic                step_err,
    output logic                err_sticky,
    output logic [AW-1:0]       err_addr
);
    disc_e                  disc_q;
    res_e                   res_q;
    logic [NPORT-1:0]       rd, wr, wcoll, rcoll, wviol, viol, commit;
    logic [NPORT*NPORT-1:0] wpeer;
    logic [NPORT*DW-1:0]    merged;

    assign disc_q = disc_e'(disc);
    assign res_q  = res_e'(res);

    for (genvar i = 0; i < NPORT; i++) begin : g_dec
        op_t op;
        assign op    = decode_op(port_vld[i], port_we[i]);
        assign rd[i] = op.rd;
        assign wr[i] = op.wr;
    end

    shm_match #(.NPORT(NPORT), .AW(AW)) u_match (
        .rd(rd), .wr(wr), .addr(port_addr),
        .wpeer(wpeer), .wcoll(wcoll), .rcoll(rcoll)
    );

    shm_merge #(.NPORT(NPORT), .DW(DW)) u_merge (
        .clk(clk), .rst(rst), .res(res_q), .wpeer(wpeer),
        .wdata(port_wdata), .merged(merged)
    );

    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            wviol[i] = wcoll[i] && (excl_write(disc_q) || res_q == RES_ERR);
            viol[i]  = wviol[i] || (rcoll[i] && excl_read(disc_q));
        end
        commit = wr & ~wviol;
    end

    shm_store #(.NPORT(NPORT), .AW(AW), .DW(DW)) u_store (
        .clk(clk), .rst(rst), .rd(rd), .commit(commit), .addr(port_addr),
        .merged(merged), .rd_vld(rd_vld), .rd_data(rd_data)
    );

    shm_errlog #(.NPORT(NPORT), .AW(AW)) u_err (
        .clk(clk), .rst(rst), .err_clr(err_clr), .viol(viol),
        .addr(port_addr), .step_err(step_err), .err_sticky(err_sticky),
        .err_addr(err_addr)
    );

    for (genvar i = 0; i < NPORT; i++) begin : g_chk
        // R8
        excl_write_chk: assert property (@(posedge clk) disable iff (rst)
            (disc_q != DISC_CRCW && wcoll[i]) |=> step_err);
        // R9
        excl_read_chk: assert property (@(posedge clk) disable iff (rst)
            (disc_q[1] && rcoll[i]) |=> (step_err && rd_vld[i]));
    end

endmodule

// File: tb/tb_shmem_resolve.sv
module tb_shmem_resolve;
    localparam int N  = 4;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] disc = '0, res = '0;
    logic [N-1:0] t_vld = '0, t_we = '0;
    logic [AW-1:0] t_addr [N];
    logic [DW-1:0] t_wd [N];
    logic err_clr = 1'b0;
    logic [N*AW-1:0] port_addr;
    logic [N*DW-1:0] port_wdata;
    logic [N-1:0] rd_vld;
    logic [N*DW-1:0] rd_data;
    logic step_err, err_sticky;
    logic [AW-1:0] err_addr;

    always #5 clk = ~clk;

    for (genvar i = 0; i < N; i++) begin : g_pack
        assign port_addr[i*AW +: AW]  = t_addr[i];
        assign port_wdata[i*DW +: DW] = t_wd[i];
    end

    shmem_resolve #(.NPORT(N), .AW(AW), .DW(DW)) dut (
        .clk(clk), .rst(rst), .disc(disc), .res(res), .port_vld(t_vld),
        .port_we(t_we), .port_addr(port_addr), .port_wdata(port_wdata),
        .err_clr(err_clr), .rd_vld(rd_vld), .rd_data(rd_data),
        .step_err(step_err), .err_sticky(err_sticky), .err_addr(err_addr)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [DW-1:0] mdl [DEPTH];
    logic [N*DW-1:0] e_rd;
    logic [N-1:0] e_vld;
    logic e_step, e_sticky;
    logic [AW-1:0] e_addr;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] resolve(input logic [1:0] r, input logic [AW-1:0] a);
        logic [DW-1:0] v = '0;
        bit first = 1;
        for (int j = 0; j < N; j++) begin
            if (t_vld[j] && t_we[j] && t_addr[j] == a) begin
                if (r == 2'd1) v = v | t_wd[j];
                else if (r == 2'd2) begin if (t_wd[j] > v) v = t_wd[j]; end
                else if (first) v = t_wd[j];
                first = 0;
            end
        end
        return v;
    endfunction

    // Applies one step and checks the registered results named by req.
    task automatic step(input string req);
        logic [N-1:0] viol = '0;
        logic [N-1:0] com = '0;
        logic [DW-1:0] nv [N];
        for (int i = 0; i < N; i++) begin
            int nw = 0, nr = 0;
            for (int j = 0; j < N; j++) begin
                if (t_addr[j] == t_addr[i] && t_vld[j]) begin
                    if (t_we[j]) nw++; else nr++;
                end
            end
            if (t_vld[i] && t_we[i]) begin
                if (nw > 1 && (disc != 2'd0 || res == 2'd3)) viol[i] = 1;
                else com[i] = 1;
                nv[i] = resolve(res, t_addr[i]);
            end
            if (t_vld[i] && !t_we[i]) begin
                e_rd[i*DW +: DW] = mdl[t_addr[i]];
                if (nr > 1 && disc[1]) viol[i] = 1;
            end
        end
        e_vld = t_vld & ~t_we;
        for (int i = 0; i < N; i++) if (com[i]) mdl[t_addr[i]] = nv[i];
        e_step = |viol;
        if (|viol) begin
            if (!e_sticky || err_clr) begin
                for (int k = N - 1; k >= 0; k--) if (viol[k]) e_addr = t_addr[k];
            end
            e_sticky = 1;
        end else if (err_clr) e_sticky = 0;
        @(posedge clk);
        @(negedge clk);
        check({req, " rd_data"}, 64'(rd_data), 64'(e_rd));
        check({req, " rd_vld"}, 64'(rd_vld), 64'(e_vld));
        check({req, " step_err"}, 64'(step_err), 64'(e_step));
        check({req, " sticky/addr"}, 64'({err_sticky, err_addr}), 64'({e_sticky, e_addr}));
        t_vld = '0; err_clr = 0;
    endtask

    task automatic wr(input int p, input logic [AW-1:0] a, input logic [DW-1:0] d);
        t_vld[p] = 1; t_we[p] = 1; t_addr[p] = a; t_wd[p] = d;
    endtask

    task automatic rdp(input int p, input logic [AW-1:0] a);
        t_vld[p] = 1; t_we[p] = 0; t_addr[p] = a;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin t_addr[i] = '0; t_wd[i] = '0; end
        for (int k = 0; k < DEPTH; k++) mdl[k] = '0;
        e_rd = '0; e_vld = '0; e_step = 0; e_sticky = 0; e_addr = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state and zeroed words
        check("R1 rd_vld", 64'(rd_vld), 64'(0));
        check("R1 step/sticky", 64'({step_err, err_sticky, err_addr}), 64'(0));
        for (int i = 0; i < N; i++) rdp(i, AW'(i + 4));
        step("R1");
        // R3: single writer, then read back
        disc = 2'd0; res = 2'd0;
        wr(2, 5, 8'h3C); step("R3");
        rdp(0, 5); step("R3");
        // R2: read sees pre-step value while another port writes it
        rdp(1, 5); wr(3, 5, 8'h11); step("R2");
        rdp(1, 5); step("R2");
        // R4 / R5 / R6: three writers, values separating the functions
        wr(1, 7, 8'h20); wr(2, 7, 8'h90); wr(3, 7, 8'h05); step("R4");
        rdp(0, 7); step("R4");
        res = 2'd1;
        wr(1, 7, 8'h20); wr(2, 7, 8'h90); wr(3, 7, 8'h05); step("R5");
        rdp(0, 7); step("R5");
        res = 2'd2;
        wr(1, 7, 8'h20); wr(2, 7, 8'h90); wr(3, 7, 8'h05); step("R6");
        rdp(0, 7); step("R6");
        // R5: broadcast key, then OR-merged match flag
        res = 2'd1;
        wr(0, 0, 8'h2A); step("R5");
        for (int i = 0; i < N; i++) rdp(i, 0);
        step("R9");
        for (int i = 0; i < N; i++) wr(i, 9, (i == 2) ? 8'h01 : 8'h00);
        step("R5");
        rdp(0, 9); step("R5");
        // R7: error resolution leaves word unchanged
        res = 2'd3;
        wr(0, 7, 8'hFF); wr(2, 7, 8'h01); step("R7");
        rdp(0, 7); step("R10");
        // R11: capture held until clear; clear alone
        wr(1, 3, 8'h44); wr(3, 3, 8'h55); step("R11");
        err_clr = 1; step("R11");
        // R8: exclusive writes
        disc = 2'd1; res = 2'd0;
        wr(1, 6, 8'hA1); wr(2, 6, 8'hA2); wr(0, 8, 8'h08); step("R8");
        rdp(0, 6); rdp(1, 8); step("R8");
        // R9: concurrent reads legal under disc 1, flagged under EREW
        err_clr = 1; rdp(0, 8); rdp(3, 8); step("R9");
        disc = 2'd2;
        rdp(1, 8); rdp(2, 8); step("R9");
        // R11: clear and new violation together -> new address captured
        disc = 2'd3;
        err_clr = 1; rdp(0, 12); rdp(3, 12); step("R11");
        // random phase with narrow address range
        void'($urandom(32'h5EED1234));
        for (int s = 0; s < 400; s++) begin
            disc = 2'($urandom); res = 2'($urandom);
            t_vld = N'($urandom); t_we = N'($urandom);
            for (int i = 0; i < N; i++) begin
                t_addr[i] = ($urandom % 4 == 0) ? AW'($urandom) : AW'($urandom % 3);
                t_wd[i] = DW'($urandom);
            end
            err_clr = ($urandom % 8) == 0;
            step("R4-R11 random");
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule